// File: doc/BRIEF.md
# Bus Width Adapter with Transfer Lock

The adapter sits between a 32-bit internal master and a set of target regions. Each region has a fixed data width (8, 16 or 32 bits) and a fixed number of states per access (2 or 3), both set by parameters. The master presents a byte, word or longword request together with a region-select value. The adapter breaks the request into as many narrow sub-accesses as the region width needs. It returns the read data assembled into one 32-bit value, or it spreads the write data over the sub-accesses.

The whole split sequence counts as one indivisible bus cycle. A lock output stays high from the first state of the first sub-access to the last state of the final one, so an arbiter cannot hand the bus to another requester in between. Instruction fetches are always widened to an aligned 32-bit longword read, whatever size is requested and whatever the width of the target region.

All 32-bit data, on both the master and the target side, uses big-endian lanes: the byte at address offset k within a longword sits on bits [31-8k : 24-8k], and its lane strobe is bit 3-k.

Top module: `bus_sizer`

## Requirements
- R1: Sub-access count. The sub-access width is the smaller of the request width and the region width. A longword on an 8-bit region gives four byte sub-accesses, and a longword on a 16-bit region gives two word sub-accesses. A word on an 8-bit region gives two byte sub-accesses. Every other combination uses one sub-access.
- R2: Sub-accesses are issued lowest address first, each at base + i × sub-width. bus_strb_o marks the lanes of the current sub-access under the lane rule in the description. Read bytes are placed on the same lanes of rdata_o, so the lowest-addressed byte is the most significant one.
- R3: Each sub-access holds bus_addr_o stable for exactly the region's state count (2 or 3 cycles). A longword on a 2-state 8-bit region therefore occupies 8 cycles.
- R4: lock_o rises in the cycle after a request is accepted. It stays high without a gap for all sub-access cycles and is low in the cycle after ready_o.
- R5: ready_o pulses for one cycle, in the final state of the last sub-access. rdata_o is valid in that cycle, and lanes outside the request read as zero.
- R6: A write request drives bus_wr_o (and never bus_rd_o) for every sub-access cycle. bus_wdata_o carries wdata_i on its natural lanes.
- R7: When fetch_i is set, the request becomes a read of the aligned longword that contains addr_i. size_i, we_i and addr_i[1:0] are ignored, including for word addresses of the form 2n+1.
- R8: A request is accepted only while the adapter is idle. Input changes while it is busy do not affect the transfer in progress, and ready_o stays low until that transfer is done.
- R9: During reset, lock_o, ready_o, bus_rd_o, bus_wr_o and bus_strb_o are all low.
- R10: Address bits below the request size are ignored: a word uses addr_i with bit 0 cleared, and a longword uses addr_i with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid; taken when idle |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | 0 byte, 1 word, 2 longword |
| we_i | input | 1 | 1 write, 0 read |
| fetch_i | input | 1 | Instruction fetch (forces aligned longword read) |
| region_i | input | RSEL_W | Target region select |
| wdata_i | input | 32 | Write data, big-endian lanes |
| ready_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Assembled read data |
| lock_o | output | 1 | Bus mastership hold |
| bus_addr_o | output | ADDR_W | Sub-access address |
| bus_rd_o | output | 1 | Sub-access read |
| bus_wr_o | output | 1 | Sub-access write |
| bus_strb_o | output | 4 | Byte-lane strobes |
| bus_wdata_o | output | 32 | Write data to target |
| bus_region_o | output | RSEL_W | Region of the current access |
| bus_rdata_i | input | 32 | Read data from target, big-endian lanes |

## Verification
The splitting logic is driven with every size on 8-, 16- and 32-bit regions. The four-, two- and one-piece cases, and the byte-versus-word lane pattern, each show up in the per-cycle address and strobe trace. Pairing 2-state and 3-state regions separates the state timing from the piece count. Fetches marked as byte writes at odd word addresses, and misaligned word or longword addresses, show whether size promotion and low-bit masking happen. Changing the inputs in the middle of a transfer shows whether a busy adapter ignores a new request.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} size_e;

  // big-endian lane mask: offset 0 is the MSB lane
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b1000 >> off;
      SZ_WORD: m = off[1] ? 4'b0011 : 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] lane_bits(input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/bsz_plan.sv
module bsz_plan import bsz_pkg::*; #(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W = 32,
  parameter int RSEL_W = 2,
  parameter logic [2*N_REGIONS-1:0] REGION_WIDTH = '0,
  parameter logic [2*N_REGIONS-1:0] REGION_STATES = '0
) (
  input  logic [RSEL_W-1:0] region_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              fetch_i,
  input  logic              we_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [1:0]        sub_sz_o,
  output logic [1:0]        n_sub_m1_o,
  output logic [1:0]        states_m1_o,
  output logic              we_o
);
  logic [1:0] reg_w [N_REGIONS];
  logic [1:0] reg_s [N_REGIONS];

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_cfg
    assign reg_w[g] = REGION_WIDTH[2*g +: 2];
    assign reg_s[g] = REGION_STATES[2*g +: 2];
  end

  logic [1:0] eff, rw, diff;

  always_comb begin
    eff = fetch_i ? SZ_LONG : ((size_i > SZ_LONG) ? SZ_LONG : size_i);
    rw  = (reg_w[region_i] > SZ_LONG) ? SZ_LONG : reg_w[region_i];
    sub_sz_o = (eff < rw) ? eff : rw;
    diff = eff - sub_sz_o;
    case (diff)
      2'd0:    n_sub_m1_o = 2'd0;
      2'd1:    n_sub_m1_o = 2'd1;
      default: n_sub_m1_o = 2'd3;
    endcase
    case (eff)
      SZ_BYTE: base_o = addr_i;
      SZ_WORD: base_o = {addr_i[ADDR_W-1:1], 1'b0};
      default: base_o = {addr_i[ADDR_W-1:2], 2'b00};
    endcase
    states_m1_o = (reg_s[region_i] >= 2'd3) ? 2'd2 : 2'd1;
    we_o = we_i & ~fetch_i;
  end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] n_sub_m1_i,
  input  logic [1:0] states_m1_i,
  output logic       busy_o,
  output logic [1:0] sub_idx_o,
  output logic       sub_end_o,
  output logic       done_o
);
  logic [1:0] st_cnt, r_nm1, r_sm1;

  assign sub_end_o = busy_o & (st_cnt == r_sm1);
  assign done_o    = sub_end_o & (sub_idx_o == r_nm1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      sub_idx_o <= '0;
      st_cnt    <= '0;
      r_nm1     <= '0;
      r_sm1     <= '0;
    end else if (start_i) begin
      busy_o    <= 1'b1;
      sub_idx_o <= '0;
      st_cnt    <= '0;
      r_nm1     <= n_sub_m1_i;
      r_sm1     <= states_m1_i;
    end else if (busy_o) begin
      if (sub_end_o) begin
        st_cnt <= '0;
        if (done_o) busy_o <= 1'b0;
        else        sub_idx_o <= sub_idx_o + 2'd1;
      end else begin
        st_cnt <= st_cnt + 2'd1;
      end
    end
  end

  // R4
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  // R3
  state_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> st_cnt <= r_sm1);
  // R5
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes import bsz_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        active_i,
  input  logic        capture_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  sub_sz_i,
  input  logic [31:0] bus_rdata_i,
  output logic [3:0]  strb_o,
  output logic [31:0] rdata_o
);
  logic [31:0] acc, lbits;

  assign strb_o  = active_i ? lane_mask(off_i, sub_sz_i) : 4'b0000;
  assign lbits   = lane_bits(strb_o);
  assign rdata_o = acc | (bus_rdata_i & lbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc <= '0;
    else if (clear_i)   acc <= '0;
    else if (capture_i) acc <= acc | (bus_rdata_i & lbits);
  end

  // R2: each sub-access fills lanes not yet filled
  lane_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> (acc & lbits) == 32'h0);
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer import bsz_pkg::*; #(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W = 32,
  parameter int RSEL_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
  // per region, 2 bits each: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit
  parameter logic [2*N_REGIONS-1:0] REGION_WIDTH = {2'd2, 2'd0, 2'd1, 2'd0},
  // per region, 2 bits each: states per access (2 or 3)
  parameter logic [2*N_REGIONS-1:0] REGION_STATES = {2'd3, 2'd3, 2'd2, 2'd2}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [RSEL_W-1:0] region_i,
  input  logic [31:0]       wdata_i,
  output logic              ready_o,
  output logic [31:0]       rdata_o,
  output logic              lock_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [3:0]        bus_strb_o,
  output logic [31:0]       bus_wdata_o,
  output logic [RSEL_W-1:0] bus_region_o,
  input  logic [31:0]       bus_rdata_i
);
  logic [ADDR_W-1:0] p_base, r_base;
  logic [1:0] p_sub_sz, p_nm1, p_sm1, r_sub_sz, sub_idx;
  logic p_we, r_we, busy, sub_end, done, accept;

  bsz_plan #(
    .N_REGIONS(N_REGIONS), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W),
    .REGION_WIDTH(REGION_WIDTH), .REGION_STATES(REGION_STATES)
  ) u_plan (
    .region_i(region_i), .addr_i(addr_i), .size_i(size_i), .fetch_i(fetch_i), .we_i(we_i),
    .base_o(p_base), .sub_sz_o(p_sub_sz), .n_sub_m1_o(p_nm1), .states_m1_o(p_sm1), .we_o(p_we)
  );

  assign accept = req_i & ~busy;

  bsz_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .n_sub_m1_i(p_nm1), .states_m1_i(p_sm1),
    .busy_o(busy), .sub_idx_o(sub_idx), .sub_end_o(sub_end), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_base       <= '0;
      r_sub_sz     <= '0;
      r_we         <= 1'b0;
      bus_wdata_o  <= '0;
      bus_region_o <= '0;
    end else if (accept) begin
      r_base       <= p_base;
      r_sub_sz     <= p_sub_sz;
      r_we         <= p_we;
      bus_wdata_o  <= wdata_i;
      bus_region_o <= region_i;
    end
  end

  assign bus_addr_o = r_base + (ADDR_W'(sub_idx) << r_sub_sz);
  assign bus_rd_o   = busy & ~r_we;
  assign bus_wr_o   = busy & r_we;
  assign lock_o     = busy;
  assign ready_o    = done;

  bsz_lanes u_lanes (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .active_i(busy),
    .capture_i(sub_end & ~r_we), .off_i(bus_addr_o[1:0]), .sub_sz_i(r_sub_sz),
    .bus_rdata_i(bus_rdata_i), .strb_o(bus_strb_o), .rdata_o(rdata_o)
  );

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));
  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && !sub_end |=> $stable(bus_addr_o));
  // R7
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && fetch_i |=> bus_addr_o[1:0] == 2'b00 && bus_rd_o);
  // R4
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !lock_o);
  // R8
  region_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && !ready_o |=> $stable(bus_region_o) && $stable(bus_wdata_o));
  // R2
  strb_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> bus_strb_o != 4'b0000);
endmodule

// File: tb/sim_bus_sizer.sv
`timescale 1ns/1ps
module sim_bus_sizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, fetch = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0] size = '0, region = '0;
  logic ready, lock, bus_rd, bus_wr;
  logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0] bus_strb;
  logic [1:0] bus_region;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // region table as specified: widths (log2 bytes) and states
  int rw_tab [4] = '{0, 1, 0, 2};
  int st_tab [4] = '{2, 2, 3, 3};

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_b(input logic [31:0] a);
    return (a[7:0] ^ 8'hA5) + {a[11:8], 4'h0};
  endfunction

  function automatic logic [31:0] mem_w(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {mem_b(b), mem_b(b + 1), mem_b(b + 2), mem_b(b + 3)};
  endfunction

  function automatic logic [3:0] exp_mask(input int off, input int nbytes);
    return 4'(((1 << nbytes) - 1) << (4 - off - nbytes));
  endfunction

  assign bus_rdata = mem_w(bus_addr);

  bus_sizer u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .size_i(size), .we_i(we),
    .fetch_i(fetch), .region_i(region), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .lock_o(lock), .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .bus_strb_o(bus_strb), .bus_wdata_o(bus_wdata), .bus_region_o(bus_region),
    .bus_rdata_i(bus_rdata)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // issue one request, trace it per cycle, compare with model
  task automatic run(input int rg, input logic [31:0] a, input logic [1:0] sz, input bit w,
                     input bit f, input logic [31:0] wd, input bit disturb, input string rq);
    int eff, sub, n, nb, st, k, bad_a, bad_w;
    logic [31:0] base, got_rd, exp_rd;
    bit seen;
    eff  = f ? 2 : int'(sz);
    sub  = (eff < rw_tab[rg]) ? eff : rw_tab[rg];
    n    = 1 << (eff - sub);
    nb   = 1 << sub;
    st   = st_tab[rg];
    base = (eff == 2) ? {a[31:2], 2'b00} : (eff == 1) ? {a[31:1], 1'b0} : a;
    exp_rd = mem_w(base) & {{8{exp_mask(int'(base[1:0]), 1 << eff) [3]}},
                            {8{exp_mask(int'(base[1:0]), 1 << eff) [2]}},
                            {8{exp_mask(int'(base[1:0]), 1 << eff) [1]}},
                            {8{exp_mask(int'(base[1:0]), 1 << eff) [0]}}};
    @(negedge clk);
    req = 1'b1; addr = a; size = sz; we = w; fetch = f; wdata = wd; region = 2'(rg);
    k = 0; bad_a = 0; bad_w = 0; seen = 1'b0; got_rd = '0;
    while (!seen && k < 40) begin
      @(negedge clk);
      if (disturb && k == 0) begin
        addr = a ^ 32'h40; region = 2'(rg ^ 1); we = ~w; wdata = ~wd; size = 2'd2;
      end
      if (lock) begin
        logic [31:0] ea;
        ea = base + 32'((k / st) * nb);
        if (bus_addr !== ea || bus_strb !== exp_mask(int'(ea[1:0]), nb)) bad_a++;
        if (w && !f) begin
          if (!bus_wr || bus_rd || bus_wdata !== wd) bad_w++;
        end else if (!bus_rd || bus_wr) bad_w++;
        k++;
      end
      if (ready) begin seen = 1'b1; got_rd = rdata; req = 1'b0; end
    end
    req = 1'b0;
    // R1 R3: piece count times states = locked cycles; ready in last one
    check(seen && k == n * st, {rq, " R1/R3 cycle count"}, 32'(k), 32'(n * st));
    // R2: address and strobe sequence
    check(bad_a == 0, {rq, " R2 addr/strb sequence"}, 32'(bad_a), 32'd0);
    check(bad_w == 0, {rq, " R6 direction/wdata"}, 32'(bad_w), 32'd0);
    if (!(w && !f)) check(got_rd === exp_rd, {rq, " R5 rdata"}, got_rd, exp_rd);
    @(negedge clk);
    // R4: released after ready
    check(!lock && !bus_rd && !bus_wr, {rq, " R4 release"}, {29'd0, lock, bus_rd, bus_wr}, 32'd0);
  endtask

  task automatic t_reset();
    check(!lock && !ready && !bus_rd && !bus_wr && bus_strb == 4'b0, "R9 reset outputs",
          {27'd0, lock, ready, bus_rd, bus_wr, |bus_strb}, 32'd0);
  endtask

  task automatic t_split_8bit();
    run(0, 32'h0000_0120, 2'd2, 1'b0, 1'b0, '0, 1'b0, "R1 long/8bit 8 states");
    run(0, 32'h0000_0132, 2'd1, 1'b0, 1'b0, '0, 1'b0, "R1 word/8bit");
    run(0, 32'h0000_0133, 2'd0, 1'b0, 1'b0, '0, 1'b0, "R2 byte/8bit");
  endtask

  task automatic t_split_16bit();
    run(1, 32'h0000_0244, 2'd2, 1'b0, 1'b0, '0, 1'b0, "R1 long/16bit");
    run(1, 32'h0000_0246, 2'd1, 1'b0, 1'b0, '0, 1'b0, "R2 word/16bit low lanes");
    run(1, 32'h0000_0241, 2'd0, 1'b0, 1'b0, '0, 1'b0, "R2 byte/16bit");
  endtask

  task automatic t_three_state();
    run(2, 32'h0000_0350, 2'd2, 1'b0, 1'b0, '0, 1'b0, "R3 long/8bit 3-state");
    run(3, 32'h0000_0458, 2'd2, 1'b0, 1'b0, '0, 1'b0, "R1 long/32bit single");
  endtask

  task automatic t_write();
    run(0, 32'h0000_0560, 2'd2, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, "R6 write long/8bit");
    run(1, 32'h0000_0562, 2'd1, 1'b1, 1'b0, 32'h1234_5678, 1'b0, "R6 write word/16bit");
  endtask

  task automatic t_fetch();
    run(0, 32'h0000_0606, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, "R7 fetch odd word/8bit");
    run(1, 32'h0000_0614, 2'd1, 1'b0, 1'b1, '0, 1'b0, "R7 fetch even word/16bit");
  endtask

  task automatic t_align();
    run(1, 32'h0000_0703, 2'd1, 1'b0, 1'b0, '0, 1'b0, "R10 misaligned word");
    run(0, 32'h0000_0717, 2'd2, 1'b0, 1'b0, '0, 1'b0, "R10 misaligned long");
  endtask

  task automatic t_busy();
    run(2, 32'h0000_0820, 2'd1, 1'b0, 1'b0, '0, 1'b1, "R8 busy read");
    run(0, 32'h0000_0830, 2'd2, 1'b1, 1'b0, 32'hA5A5_0F0F, 1'b1, "R8 busy write");
  endtask

  initial begin : wd
    #1_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_split_8bit();
    t_split_16bit();
    t_three_state();
    t_write();
    t_fetch();
    t_align();
    t_busy();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule